// File: doc/BRIEF.md
# DMA Command Queue with List Sequencer

This block takes transfer commands from a processor, parks them in a queue and runs them without further help, so the submitter is free the moment its command is taken. A plain command moves one contiguous block between a scratchpad address and a main-memory address, in either direction. A list command names a table of 64-bit elements in the scratchpad. The block reads that table one element at a time and issues one transfer per element, which gives a scatter-gather sequence.

Each transfer leaves on a memory-request port as a valid/ready request and finishes when an acknowledge pulse returns. Only one transfer is in flight at a time. Commands carry a 5-bit tag, and a sticky per-tag done bit rises once the last transfer of that command is acknowledged. Commands arrive on one valid/ready port. A side-band pin marks a command as coming from a remote agent rather than the local processor.

Back-pressure rules: a command is taken on any cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low only while the queue is full. A valid command must hold its fields until it is taken. The block holds `req_*` fields stable while `req_valid` is high and `req_ready` is low. The table read port follows the same valid/ready rule. Its response comes back as a one-cycle `tbl_rsp_valid` pulse, which the block always accepts.

Top module: `dma_cmd_engine`

## Requirements
- R1: A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high whenever the queue is not full, so the submitter is released in that same cycle.
- R2: A plain command (`cmd_list`=0) whose `cmd_size` exceeds 16384 bytes is not queued and issues no request. It produces a one-cycle `cmd_reject` pulse in the cycle after it is taken. A size of exactly 16384 is accepted.
- R3: A list command whose element count (`cmd_size`) exceeds 2048 is rejected in the same way as R2.
- R4: A list command marked `cmd_remote`=1 is rejected as in R2. A plain command from the remote side is accepted.
- R5: A plain command produces exactly one request carrying its local address, main address, size and tag. `req_put` is 0 for get (main to scratchpad) and 1 for put.
- R6: For a list command, `cmd_maddr` holds the table's scratchpad address and `cmd_size` holds the element count. Element i is read at table + 8*i. Bits 63:32 of an element give the size and bits 31:0 give the main address. The local address starts at `cmd_laddr` and advances by each issued element's size. Elements are issued in table order.
- R7: A list element larger than 16384 bytes issues no request and pulses `elem_err` for one cycle. The local address does not advance, and the walk continues with the next element.
- R8: The queue holds 16 commands and starts them in arrival order. `cmd_full` is high and `cmd_ready` is low while all 16 are occupied.
- R9: `tag_done[t]` rises after the acknowledge of the last transfer of a command with tag t. It is cleared when a new command with tag t is queued, and clearing takes priority over setting in the same cycle.
- R10: A list command with zero elements sets its done bit without issuing any request or table read.
- R11: While `req_valid` is high and `req_ready` is low, `req_valid` and all `req_*` fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken this cycle if valid |
| cmd_remote | input | 1 | Command comes from a remote agent |
| cmd_list | input | 1 | Command is a list command |
| cmd_put | input | 1 | 1 = scratchpad to memory, 0 = memory to scratchpad |
| cmd_tag | input | 5 | Completion tag |
| cmd_laddr | input | 32 | Scratchpad data address |
| cmd_maddr | input | 32 | Main address, or table address for a list |
| cmd_size | input | 32 | Byte count, or element count for a list |
| cmd_full | output | 1 | Queue occupied to capacity |
| cmd_reject | output | 1 | Pulse: the last taken command was refused |
| req_valid | output | 1 | Transfer request offered |
| req_ready | input | 1 | Transfer request taken |
| req_put | output | 1 | Transfer direction |
| req_tag | output | 5 | Tag of the owning command |
| req_laddr | output | 32 | Scratchpad address of the transfer |
| req_maddr | output | 32 | Main address of the transfer |
| req_size | output | 32 | Byte count of the transfer |
| req_ack | input | 1 | Pulse: the in-flight transfer finished |
| tbl_rd_valid | output | 1 | Table element read offered |
| tbl_rd_ready | input | 1 | Table element read taken |
| tbl_rd_addr | output | 32 | Scratchpad address of the element |
| tbl_rsp_valid | input | 1 | Pulse: element data present |
| tbl_rsp_data | input | 64 | Element data |
| elem_err | output | 1 | Pulse: a list element was oversized and skipped |
| tag_done | output | 32 | Sticky completion bit per tag |

## Verification
The bench builds the block with its default parameters: a 16-entry queue, a 16384-byte transfer limit and a 2048-element list limit. With these values the exact limits can be probed one step either side. A 17-command burst with stalled memory fills the queue plus the command held in the sequencer, which exposes the full flag and the start order. Short tables of three elements, with one oversized entry in the middle, cover address advance, skipping and completion timing without long runs.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int ADDR_W = 32;
  localparam int TAG_W  = 5;

  typedef struct packed {
    logic              put;
    logic              is_list;
    logic [TAG_W-1:0]  tag;
    logic [ADDR_W-1:0] laddr;
    logic [ADDR_W-1:0] maddr;
    logic [ADDR_W-1:0] size;
  } dma_cmd_t;

  localparam int CMD_W = $bits(dma_cmd_t);

  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE,
    S_WAIT_ACK,
    S_FETCH,
    S_WAIT_ELEM
  } seq_state_t;
endpackage

// File: rtl/dma_cmd_filter.sv
module dma_cmd_filter
  import dma_pkg::*;
#(
  parameter int MAX_XFER = 16384,
  parameter int MAX_LIST = 2048
) (
  input  logic              is_list,
  input  logic              remote,
  input  logic [ADDR_W-1:0] size,
  output logic              ok
);
  localparam logic [ADDR_W-1:0] XFER_LIM = ADDR_W'(MAX_XFER);
  localparam logic [ADDR_W-1:0] LIST_LIM = ADDR_W'(MAX_LIST);

  always_comb begin
    if (is_list) ok = !remote && (size <= LIST_LIM);
    else         ok = (size <= XFER_LIM);
  end
endmodule

// File: rtl/dma_cmd_fifo.sv
module dma_cmd_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign rdata = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r8_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  a_r8_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
endmodule

// File: rtl/dma_tag_done.sv
module dma_tag_done
  import dma_pkg::*;
#(
  parameter int TAGS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_valid,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_valid,
  input  logic [TAG_W-1:0] clr_tag,
  output logic [TAGS-1:0]  done
);
  for (genvar g = 0; g < TAGS; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   done[g] <= 1'b0;
      else if (clr_valid && clr_tag == TAG_W'(g))   done[g] <= 1'b0;
      else if (set_valid && set_tag == TAG_W'(g))   done[g] <= 1'b1;
    end
  end

  // R9: a done bit only rises after a completion report
  a_r9_done_needs_fin: assert property (@(posedge clk) disable iff (!rst_n)
    ((done & ~$past(done)) != '0) |-> $past(set_valid));
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int MAX_XFER = 16384,
  parameter int MAX_LIST = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_valid,
  input  dma_cmd_t          head,
  output logic              pop,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_put,
  output logic [TAG_W-1:0]  req_tag,
  output logic [ADDR_W-1:0] req_laddr,
  output logic [ADDR_W-1:0] req_maddr,
  output logic [ADDR_W-1:0] req_size,
  input  logic              req_ack,
  output logic              tbl_rd_valid,
  input  logic              tbl_rd_ready,
  output logic [ADDR_W-1:0] tbl_rd_addr,
  input  logic              tbl_rsp_valid,
  input  logic [63:0]       tbl_rsp_data,
  output logic              fin_valid,
  output logic [TAG_W-1:0]  fin_tag,
  output logic              elem_err
);
  localparam int IDX_W = $clog2(MAX_LIST + 1);
  localparam logic [ADDR_W-1:0] XFER_LIM = ADDR_W'(MAX_XFER);

  seq_state_t        state;
  dma_cmd_t          cur;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] run_laddr;
  logic [ADDR_W-1:0] elem_size;
  logic              last;

  assign elem_size    = tbl_rsp_data[63:32];
  assign last         = (ADDR_W'(idx) == cur.size - 1'b1);
  assign pop          = (state == S_IDLE) && head_valid;
  assign req_valid    = (state == S_ISSUE);
  assign tbl_rd_valid = (state == S_FETCH);
  assign tbl_rd_addr  = cur.maddr + (ADDR_W'(idx) << 3);
  assign req_put      = cur.put;
  assign req_tag      = cur.tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur       <= '0;
      idx       <= '0;
      run_laddr <= '0;
      req_laddr <= '0;
      req_maddr <= '0;
      req_size  <= '0;
      fin_valid <= 1'b0;
      fin_tag   <= '0;
      elem_err  <= 1'b0;
    end else begin
      fin_valid <= 1'b0;
      elem_err  <= 1'b0;
      unique case (state)
        S_IDLE: if (head_valid) begin
          cur <= head;
          if (!head.is_list) begin
            req_laddr <= head.laddr;
            req_maddr <= head.maddr;
            req_size  <= head.size;
            state     <= S_ISSUE;
          end else if (head.size == '0) begin
            fin_valid <= 1'b1;
            fin_tag   <= head.tag;
          end else begin
            idx       <= '0;
            run_laddr <= head.laddr;
            state     <= S_FETCH;
          end
        end
        S_ISSUE: if (req_ready) state <= S_WAIT_ACK;
        S_WAIT_ACK: if (req_ack) begin
          if (!cur.is_list || last) begin
            fin_valid <= 1'b1;
            fin_tag   <= cur.tag;
            state     <= S_IDLE;
          end else begin
            run_laddr <= run_laddr + req_size;
            idx       <= idx + 1'b1;
            state     <= S_FETCH;
          end
        end
        S_FETCH: if (tbl_rd_ready) state <= S_WAIT_ELEM;
        S_WAIT_ELEM: if (tbl_rsp_valid) begin
          if (elem_size > XFER_LIM) begin
            elem_err <= 1'b1;
            if (last) begin
              fin_valid <= 1'b1;
              fin_tag   <= cur.tag;
              state     <= S_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_FETCH;
            end
          end else begin
            req_laddr <= run_laddr;
            req_maddr <= tbl_rsp_data[31:0];
            req_size  <= elem_size;
            state     <= S_ISSUE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_laddr)
      && $stable(req_maddr) && $stable(req_size) && $stable(req_tag)));
  a_r2_req_size_max: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_size <= XFER_LIM));
  // R6: a table read and a transfer are never offered together
  a_r6_one_active: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !tbl_rd_valid);
endmodule

// File: rtl/dma_cmd_engine.sv
module dma_cmd_engine
  import dma_pkg::*;
#(
  parameter int QDEPTH   = 16,
  parameter int MAX_XFER = 16384,
  parameter int MAX_LIST = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_remote,
  input  logic              cmd_list,
  input  logic              cmd_put,
  input  logic [TAG_W-1:0]  cmd_tag,
  input  logic [ADDR_W-1:0] cmd_laddr,
  input  logic [ADDR_W-1:0] cmd_maddr,
  input  logic [ADDR_W-1:0] cmd_size,
  output logic              cmd_full,
  output logic              cmd_reject,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_put,
  output logic [TAG_W-1:0]  req_tag,
  output logic [ADDR_W-1:0] req_laddr,
  output logic [ADDR_W-1:0] req_maddr,
  output logic [ADDR_W-1:0] req_size,
  input  logic              req_ack,
  output logic              tbl_rd_valid,
  input  logic              tbl_rd_ready,
  output logic [ADDR_W-1:0] tbl_rd_addr,
  input  logic              tbl_rsp_valid,
  input  logic [63:0]       tbl_rsp_data,
  output logic              elem_err,
  output logic [(1<<TAG_W)-1:0] tag_done
);
  localparam int TAGS = 1 << TAG_W;

  logic       ok, accept, push, pop, empty;
  logic       fin_valid;
  logic [TAG_W-1:0] fin_tag;
  dma_cmd_t   in_cmd, head;
  logic [CMD_W-1:0] head_raw;

  assign cmd_ready = !cmd_full;
  assign accept    = cmd_valid && cmd_ready;
  assign push      = accept && ok;
  assign in_cmd    = '{put: cmd_put, is_list: cmd_list, tag: cmd_tag,
                       laddr: cmd_laddr, maddr: cmd_maddr, size: cmd_size};
  assign head      = dma_cmd_t'(head_raw);

  dma_cmd_filter #(.MAX_XFER(MAX_XFER), .MAX_LIST(MAX_LIST)) u_filter (
    .is_list(cmd_list), .remote(cmd_remote), .size(cmd_size), .ok(ok));

  dma_cmd_fifo #(.DEPTH(QDEPTH), .W(CMD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .wdata(in_cmd), .pop(pop),
    .rdata(head_raw), .full(cmd_full), .empty(empty));

  dma_seq #(.MAX_XFER(MAX_XFER), .MAX_LIST(MAX_LIST)) u_seq (
    .clk(clk), .rst_n(rst_n), .head_valid(!empty), .head(head), .pop(pop),
    .req_valid(req_valid), .req_ready(req_ready), .req_put(req_put),
    .req_tag(req_tag), .req_laddr(req_laddr), .req_maddr(req_maddr),
    .req_size(req_size), .req_ack(req_ack), .tbl_rd_valid(tbl_rd_valid),
    .tbl_rd_ready(tbl_rd_ready), .tbl_rd_addr(tbl_rd_addr),
    .tbl_rsp_valid(tbl_rsp_valid), .tbl_rsp_data(tbl_rsp_data),
    .fin_valid(fin_valid), .fin_tag(fin_tag), .elem_err(elem_err));

  dma_tag_done #(.TAGS(TAGS)) u_done (
    .clk(clk), .rst_n(rst_n), .set_valid(fin_valid), .set_tag(fin_tag),
    .clr_valid(push), .clr_tag(cmd_tag), .done(tag_done));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_reject <= 1'b0;
    else        cmd_reject <= accept && !ok;
  end

  a_r4_remote_list_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_list && cmd_remote) |=> cmd_reject);
  a_r2_oversize_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_list && cmd_size > ADDR_W'(MAX_XFER)) |=> cmd_reject);
endmodule

// File: tb/test_dma_cmd_engine.sv
module test_dma_cmd_engine;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic cmd_valid = 0, cmd_remote = 0, cmd_list = 0, cmd_put = 0;
  logic [4:0]  cmd_tag = 0;
  logic [31:0] cmd_laddr = 0, cmd_maddr = 0, cmd_size = 0;
  logic cmd_ready, cmd_full, cmd_reject, req_valid, req_put, req_ack = 0;
  logic req_ready = 0;
  logic [4:0]  req_tag;
  logic [31:0] req_laddr, req_maddr, req_size, tbl_rd_addr;
  logic tbl_rd_valid, tbl_rsp_valid = 0, elem_err;
  logic [63:0] tbl_rsp_data = 0;
  logic [31:0] tag_done;

  dma_cmd_engine i_dma_cmd_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_remote(cmd_remote), .cmd_list(cmd_list), .cmd_put(cmd_put),
    .cmd_tag(cmd_tag), .cmd_laddr(cmd_laddr), .cmd_maddr(cmd_maddr),
    .cmd_size(cmd_size), .cmd_full(cmd_full), .cmd_reject(cmd_reject),
    .req_valid(req_valid), .req_ready(req_ready), .req_put(req_put),
    .req_tag(req_tag), .req_laddr(req_laddr), .req_maddr(req_maddr),
    .req_size(req_size), .req_ack(req_ack), .tbl_rd_valid(tbl_rd_valid),
    .tbl_rd_ready(1'b1), .tbl_rd_addr(tbl_rd_addr), .tbl_rsp_valid(tbl_rsp_valid),
    .tbl_rsp_data(tbl_rsp_data), .elem_err(elem_err), .tag_done(tag_done));

  int n_chk = 0, n_bad = 0;
  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: log requests, acknowledge two cycles after handshake
  logic [31:0] log_la [64], log_ma [64], log_sz [64];
  logic        log_put [64];
  logic [4:0]  log_tag [64];
  int nlog = 0, ack_cnt = 0, n_elem_err = 0, n_tbl_rd = 0;
  logic [63:0] tbl [16];
  logic        rsp_pend = 0;
  logic [31:0] rsp_addr = 0;

  always @(negedge clk) begin
    req_ack = 0;
    if (ack_cnt != 0) begin
      ack_cnt = ack_cnt - 1;
      if (ack_cnt == 0) req_ack = 1;
    end
    if (req_valid && req_ready && nlog < 64) begin
      log_la[nlog] = req_laddr; log_ma[nlog] = req_maddr; log_sz[nlog] = req_size;
      log_put[nlog] = req_put;  log_tag[nlog] = req_tag;
      nlog++;
      ack_cnt = 2;
    end
    tbl_rsp_valid = 0;
    if (rsp_pend) begin
      tbl_rsp_valid = 1;
      tbl_rsp_data  = tbl[(rsp_addr - 32'h100) >> 3];
      rsp_pend = 0;
    end
    if (tbl_rd_valid) begin
      rsp_pend = 1; rsp_addr = tbl_rd_addr; n_tbl_rd++;
    end
    if (elem_err) n_elem_err++;
  end

  task automatic submit(input logic rem, input logic lst, input logic put,
                        input logic [4:0] tag, input logic [31:0] la,
                        input logic [31:0] ma, input logic [31:0] sz,
                        output logic rej);
    @(negedge clk);
    cmd_valid = 1; cmd_remote = rem; cmd_list = lst; cmd_put = put;
    cmd_tag = tag; cmd_laddr = la; cmd_maddr = ma; cmd_size = sz;
    for (int w = 0; w < 200 && !cmd_ready; w++) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    rej = cmd_reject;
  endtask

  task automatic wait_log(input int target);
    for (int w = 0; w < 600 && nlog < target; w++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  // vector: rej, remote, put, tag, size, maddr, laddr
  localparam int VW = 104;
  localparam logic [VW-1:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 5'd1,  32'd64,      32'h0001_0000, 32'h0000_2000},
    {1'b0, 1'b0, 1'b1, 5'd2,  32'd16384,   32'h0002_0000, 32'h0000_3000},
    {1'b1, 1'b0, 1'b0, 5'd3,  32'd16385,   32'h0003_0000, 32'h0000_4000},
    {1'b0, 1'b1, 1'b1, 5'd4,  32'd256,     32'h0004_0000, 32'h0000_5000},
    {1'b1, 1'b1, 1'b0, 5'd5,  32'h1_0000,  32'h0005_0000, 32'h0000_6000},
    {1'b0, 1'b0, 1'b1, 5'd31, 32'd1,       32'h0006_0000, 32'h0000_7000}
  };

  initial begin
    logic rej;
    int base;
    tbl[0] = {32'd32, 32'h000A_0000};
    tbl[1] = {32'd20000, 32'h000B_0000};
    tbl[2] = {32'd16, 32'h000C_0000};
    for (int k = 3; k < 16; k++) tbl[k] = '0;
    repeat (3) @(negedge clk);
    // R1 R8 R9 reset state
    chk("R1 ready after reset", cmd_ready, 1);
    chk("R8 full after reset", cmd_full, 0);
    chk("R9 done after reset", tag_done, 0);
    rst_n = 1;
    req_ready = 1;
    @(negedge clk);
    chk("R11 no request after reset", req_valid, 0);

    // vector walk: R2 R4 R5 R9
    for (int v = 0; v < 6; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      base = nlog;
      submit(e[102], 1'b0, e[101], e[100:96], e[31:0], e[63:32], e[95:64], rej);
      chk("R2 R4 reject flag", rej, e[103]);
      if (e[103]) begin
        repeat (8) @(negedge clk);
        chk("R2 R4 rejected issues nothing", nlog, base);
        chk("R2 R4 rejected tag not done", tag_done[e[100:96]], 0);
      end else begin
        wait_log(base + 1);
        chk("R5 one request", nlog, base + 1);
        chk("R5 laddr", log_la[base], e[31:0]);
        chk("R5 maddr", log_ma[base], e[63:32]);
        chk("R5 size", log_sz[base], e[95:64]);
        chk("R5 direction", log_put[base], e[101]);
        chk("R5 tag", log_tag[base], e[100:96]);
        repeat (5) @(negedge clk);
        chk("R9 done after ack", tag_done[e[100:96]], 1);
      end
    end

    // R11: stalled request keeps its fields
    req_ready = 0;
    base = nlog;
    submit(1'b0, 1'b0, 1'b0, 5'd20, 32'h100, 32'h0009_0000, 32'd8, rej);
    repeat (4) @(negedge clk);
    chk("R11 held valid", req_valid, 1);
    chk("R11 held maddr", req_maddr, 32'h0009_0000);
    req_ready = 1;
    wait_log(base + 1);
    repeat (5) @(negedge clk);

    // R6 R7 list walk with an oversized middle element
    base = nlog;
    submit(1'b0, 1'b1, 1'b0, 5'd7, 32'h4000, 32'h100, 32'd3, rej);
    chk("R6 list accepted", rej, 0);
    wait_log(base + 1);
    chk("R9 not done mid-list", tag_done[7], 0);
    wait_log(base + 2);
    chk("R6 first laddr", log_la[base], 32'h4000);
    chk("R6 first maddr", log_ma[base], 32'h000A_0000);
    chk("R6 first size", log_sz[base], 32'd32);
    chk("R7 laddr not advanced by skipped", log_la[base+1], 32'h4020);
    chk("R6 third maddr", log_ma[base+1], 32'h000C_0000);
    chk("R6 third size", log_sz[base+1], 32'd16);
    repeat (6) @(negedge clk);
    chk("R7 one elem_err pulse", n_elem_err, 1);
    chk("R7 two requests only", nlog, base + 2);
    chk("R9 list done", tag_done[7], 1);

    // R10 zero-count list
    base = nlog;
    begin
      int rd0;
      rd0 = n_tbl_rd;
      submit(1'b0, 1'b1, 1'b1, 5'd8, 32'h0, 32'h100, 32'd0, rej);
      repeat (5) @(negedge clk);
      chk("R10 accepted", rej, 0);
      chk("R10 no request", nlog, base);
      chk("R10 no table read", n_tbl_rd, rd0);
      chk("R10 done set", tag_done[8], 1);
    end

    // R4 remote list, R3 count limit
    submit(1'b1, 1'b1, 1'b0, 5'd9, 32'h0, 32'h100, 32'd1, rej);
    chk("R4 remote list rejected", rej, 1);
    submit(1'b0, 1'b1, 1'b0, 5'd10, 32'h0, 32'h100, 32'd2049, rej);
    chk("R3 2049 elements rejected", rej, 1);
    repeat (5) @(negedge clk);
    chk("R3 R4 nothing issued", nlog, base);

    // R8 R1 R9 queue fill with stalled memory, then order
    req_ready = 0;
    base = nlog;
    for (int i = 0; i < 17; i++) begin
      submit(1'b0, 1'b0, 1'b0, 5'(i + 1), 32'h0, 32'(i) << 8, 32'd4, rej);
      if (i == 0) chk("R9 done cleared on reuse", tag_done[1], 0);
    end
    repeat (3) @(negedge clk);
    chk("R8 full after 17", cmd_full, 1);
    chk("R1 ready low when full", cmd_ready, 0);
    req_ready = 1;
    wait_log(base + 17);
    chk("R8 all issued", nlog, base + 17);
    for (int i = 0; i < 17; i++)
      chk("R8 start order", log_ma[base + i], 32'(i) << 8);
    @(negedge clk);
    chk("R1 ready after drain", cmd_ready, 1);
    finish_run();
  end
endmodule